// File: doc/BRIEF.md
# Three-Wire DAC Host Command Sequencer

This block drives the serial data, serial clock and latch strobe of a loop-current DAC from the host side. It stands in for the small microcontroller that would otherwise bit-bang those three lines. A command carries a 16-bit code, an alarm-range flag and an operation. The operation can shift the code into the DAC's input register, strobe the latch so that the DAC register takes the previously shifted code, or do both in sequence.

The DAC tells a normal-range word from an alarm-range word by the number of clock pulses it sees between strobes. In alarm mode the sequencer therefore sends eight zero bits ahead of the code. The length of every half-period of the serial waveform comes from a divider value that is captured when the command is accepted. Commands are taken through a valid/ready handshake. A one-cycle done pulse marks the end of each command.

Top module: `dac3w_host_seq`

## Requirements
- R1: Operation code 01 (shift only) sends the frame on `ser_dat`/`ser_clk` and leaves `ser_lat` low for the whole command.
- R2: Operation code 10 (strobe only) produces no `ser_clk` pulse. `ser_lat` stays low for one half-period and then goes high for one half-period.
- R3: Operation code 11 (shift then strobe) sends the frame first and then performs the strobe sequence of R2 within the same command.
- R4: Frame bits leave most significant first. `ser_dat` is steady while `ser_clk` is high and changes only in cycles where `ser_clk` is low, so each bit is valid for a full low half-period before its rising edge.
- R5: With `cmd_alarm` low the frame is the 16-bit code, giving exactly 16 clock pulses. With `cmd_alarm` high the frame is 8 zero bits followed by the code, giving 24 clock pulses.
- R6: `ser_lat` is high only while `ser_clk` is low, and only after `ser_clk` has been low for one full half-period.
- R7: One half-period lasts `half_div`+1 core cycles, using the value sampled at acceptance. Changes to `half_div` during a command have no effect on that command.
- R8: After reset and between commands, `ser_clk`, `ser_lat` and `ser_dat` are low and `cmd_ready` is high.
- R9: A command is accepted on a cycle with `cmd_valid` and `cmd_ready` both high. `cmd_ready` is low from the next cycle until the command ends, and `cmd_valid` is ignored during that time. `done` is high for exactly one cycle, right after the last waveform cycle. Operation code 00 produces only the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_op | input | 2 | Bit 0 shift frame, bit 1 strobe latch |
| cmd_code | input | 16 | DAC code |
| cmd_alarm | input | 1 | Alarm-range frame select |
| half_div | input | 8 | Half-period length minus one, in core cycles |
| done | output | 1 | One-cycle end-of-command pulse |
| ser_dat | output | 1 | Serial data to DAC |
| ser_clk | output | 1 | Serial clock to DAC |
| ser_lat | output | 1 | Latch strobe to DAC |

## Verification
A wrong phase counter shows up as a half-period of the wrong length at the first `ser_clk` edge. That is at most `half_div`+1 cycles after acceptance. A wrong bit counter or shift register shows up as a misplaced or missing clock pulse or data bit within the frame. A bad state register leaves `ser_lat`, `cmd_ready` or `done` out of step on the very cycle it goes wrong. The bench therefore compares all five outputs against a behavioural expected-waveform queue on every cycle, rather than only at the end of each command.

// File: rtl/dac3w_pkg.sv
package dac3w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_HIGH   = 3'd2,
    ST_GAP    = 3'd3,
    ST_STROBE = 3'd4,
    ST_FIN    = 3'd5
  } seq_state_e;

  localparam int unsigned OP_W         = 2;
  localparam int unsigned OP_SHIFT_BIT = 0;
  localparam int unsigned OP_LATCH_BIT = 1;
endpackage

// File: rtl/dac3w_tick.sv
module dac3w_tick #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_in,
  output logic             expire
);
  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    div_d = accept ? div_in : div_q;
    if (restart)
      cnt_d = div_d;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end

  assign expire = (cnt_q == '0);

  AST_DIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(div_q)) else $error("divider changed mid-command"); // R7
endmodule

// File: rtl/dac3w_shifter.sv
module dac3w_shifter #(
  parameter int unsigned CODE_W = 16,
  parameter int unsigned PAD_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              alarm,
  input  logic [CODE_W-1:0] code,
  input  logic              shift,
  output logic              msb,
  output logic              last
);
  localparam int unsigned FRAME_W = CODE_W + PAD_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]   bits_q, bits_d;

  always_comb begin
    sr_d   = sr_q;
    bits_d = bits_q;
    if (load) begin
      if (alarm) begin
        sr_d   = {{PAD_W{1'b0}}, code};
        bits_d = CNT_W'(FRAME_W);
      end else begin
        sr_d   = {code, {PAD_W{1'b0}}};
        bits_d = CNT_W'(CODE_W);
      end
    end else if (shift) begin
      sr_d   = {sr_q[FRAME_W-2:0], 1'b0};
      bits_d = bits_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      bits_q <= '0;
    end else begin
      sr_q   <= sr_d;
      bits_q <= bits_d;
    end
  end

  assign msb  = sr_q[FRAME_W-1];
  assign last = (bits_q == CNT_W'(1));

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> (bits_q != '0)) else $error("shift past end of frame"); // R5
endmodule

// File: rtl/dac3w_ctrl.sv
module dac3w_ctrl
  import dac3w_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [OP_W-1:0] cmd_op,
  input  logic            expire,
  input  logic            last,
  input  logic            msb,
  output logic            accept,
  output logic            restart,
  output logic            shift,
  output logic            cmd_ready,
  output logic            done,
  output logic            ser_dat,
  output logic            ser_clk,
  output logic            ser_lat
);
  seq_state_e      st_q, st_d;
  logic [OP_W-1:0] op_q, op_d;
  logic            timed;

  assign cmd_ready = (st_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign timed     = (st_q == ST_SETUP) || (st_q == ST_HIGH) ||
                     (st_q == ST_GAP)   || (st_q == ST_STROBE);
  assign restart   = accept || (timed && expire);
  assign shift     = (st_q == ST_HIGH) && expire;

  always_comb begin
    st_d = st_q;
    op_d = accept ? cmd_op : op_q;
    unique case (st_q)
      ST_IDLE:
        if (accept) begin
          if (cmd_op[OP_SHIFT_BIT])      st_d = ST_SETUP;
          else if (cmd_op[OP_LATCH_BIT]) st_d = ST_GAP;
          else                           st_d = ST_FIN;
        end
      ST_SETUP:  if (expire) st_d = ST_HIGH;
      ST_HIGH:
        if (expire) begin
          if (!last)                   st_d = ST_SETUP;
          else if (op_q[OP_LATCH_BIT]) st_d = ST_GAP;
          else                         st_d = ST_FIN;
        end
      ST_GAP:    if (expire) st_d = ST_STROBE;
      ST_STROBE: if (expire) st_d = ST_FIN;
      ST_FIN:    st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      op_q <= '0;
    end else begin
      st_q <= st_d;
      op_q <= op_d;
    end
  end

  assign ser_clk = (st_q == ST_HIGH);
  assign ser_lat = (st_q == ST_STROBE);
  assign ser_dat = ((st_q == ST_SETUP) || (st_q == ST_HIGH)) && msb;
  assign done    = (st_q == ST_FIN);

  AST_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_dat) |-> !ser_clk) else $error("data moved with clock high"); // R4
  AST_LATCH_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_lat) |-> ($past(!ser_clk) && !ser_clk)) else $error("strobe overlaps clock"); // R6
  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!ser_clk && !ser_lat && !ser_dat)) else $error("lines active while idle"); // R8
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !cmd_ready) else $error("ready stayed high after accept"); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && cmd_ready)) else $error("done longer than one cycle"); // R9
  AST_NO_CLK_STROBE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && !$past(ser_clk)) |-> op_q[OP_SHIFT_BIT]) else $error("clock in strobe-only op"); // R2
endmodule

// File: rtl/dac3w_host_seq.sv
module dac3w_host_seq
  import dac3w_pkg::*;
#(
  parameter int unsigned CODE_W = 16,
  parameter int unsigned PAD_W  = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic              cmd_alarm,
  input  logic [DIV_W-1:0]  half_div,
  output logic              done,
  output logic              ser_dat,
  output logic              ser_clk,
  output logic              ser_lat
);
  logic accept, restart, shift, expire, last, msb;

  dac3w_tick #(.DIV_W(DIV_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .restart (restart),
    .div_in  (half_div),
    .expire  (expire)
  );

  dac3w_shifter #(.CODE_W(CODE_W), .PAD_W(PAD_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .alarm (cmd_alarm),
    .code  (cmd_code),
    .shift (shift),
    .msb   (msb),
    .last  (last)
  );

  dac3w_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .expire    (expire),
    .last      (last),
    .msb       (msb),
    .accept    (accept),
    .restart   (restart),
    .shift     (shift),
    .cmd_ready (cmd_ready),
    .done      (done),
    .ser_dat   (ser_dat),
    .ser_clk   (ser_clk),
    .ser_lat   (ser_lat)
  );
endmodule

// File: tb/dac3w_host_seq_tb.sv
module dac3w_host_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic       cmd_ready;
  logic [1:0] cmd_op;
  logic [15:0] cmd_code;
  logic       cmd_alarm;
  logic [7:0] half_div;
  logic       done, ser_dat, ser_clk, ser_lat;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit chk_on = 1'b0;
  string cur_req = "R8";
  logic [4:0] exp_q[$];

  always #2 clk = ~clk;

  dac3w_host_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_code(cmd_code), .cmd_alarm(cmd_alarm),
    .half_div(half_div), .done(done), .ser_dat(ser_dat),
    .ser_clk(ser_clk), .ser_lat(ser_lat)
  );

  // expected {ready, done, clk, dat, lat} per cycle
  always @(negedge clk) begin
    if (chk_on) begin
      logic [4:0] e;
      logic [4:0] a;
      e = (exp_q.size() != 0) ? exp_q.pop_front() : 5'b10000;
      a = {cmd_ready, done, ser_clk, ser_dat, ser_lat};
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s cycle %0d: {rdy,done,clk,dat,lat} actual %b expected %b",
                 cur_req, cycles, a, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL R9 watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  task automatic model(input logic [1:0] op, input logic [15:0] code,
                       input logic alarm, input int div);
    int h = div + 1;
    int n = alarm ? 24 : 16;
    logic [23:0] frame = alarm ? {8'h00, code} : {code, 8'h00};
    if (op[0]) begin
      for (int i = 0; i < n; i++) begin
        for (int k = 0; k < h; k++) exp_q.push_back({3'b000, frame[23-i], 1'b0});
        for (int k = 0; k < h; k++) exp_q.push_back({3'b001, frame[23-i], 1'b0});
      end
    end
    if (op[1]) begin
      for (int k = 0; k < h; k++) exp_q.push_back(5'b00000);
      for (int k = 0; k < h; k++) exp_q.push_back(5'b00001);
    end
    exp_q.push_back(5'b01000);
  endtask

  task automatic issue(input string req, input logic [1:0] op, input logic [15:0] code,
                       input logic alarm, input logic [7:0] div, input int busy_poke);
    while (exp_q.size() != 0) @(posedge clk);
    @(posedge clk);
    #1;
    cur_req   = req;
    cmd_valid = 1'b1; cmd_op = op; cmd_code = code; cmd_alarm = alarm; half_div = div;
    @(posedge clk);
    #1;
    model(op, code, alarm, int'(div));
    // R7: inputs scrambled after acceptance must not matter
    cmd_code = ~code; cmd_alarm = ~alarm; half_div = div + 8'd3; cmd_op = ~op;
    // R9: valid held while busy is ignored
    for (int i = 0; i < busy_poke; i++) @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    while (exp_q.size() != 0) @(posedge clk);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_code = '0;
    cmd_alarm = 1'b0; half_div = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;  // R8 reset state
    if ({cmd_ready, done, ser_clk, ser_dat, ser_lat} !== 5'b10000) begin
      fails++;
      $display("FAIL R8 reset: actual %b expected 10000",
               {cmd_ready, done, ser_clk, ser_dat, ser_lat});
    end
    @(posedge clk); #1 rst_n = 1'b1;
    chk_on = 1'b1;
    repeat (4) @(posedge clk);
    issue("R1 R4 R5 shift-only normal", 2'b01, 16'hA5C3, 1'b0, 8'd0, 0);
    issue("R2 R6 strobe-only", 2'b10, 16'h1234, 1'b0, 8'd2, 0);
    issue("R3 R5 shift+strobe alarm", 2'b11, 16'h8001, 1'b1, 8'd1, 0);
    issue("R3 R7 shift+strobe normal", 2'b11, 16'hFFFF, 1'b0, 8'd3, 0);
    issue("R1 R5 shift-only alarm zeros", 2'b01, 16'h0000, 1'b1, 8'd0, 0);
    issue("R9 no-op done only", 2'b00, 16'hBEEF, 1'b0, 8'd5, 0);
    issue("R9 busy valid ignored", 2'b11, 16'h6D2B, 1'b0, 8'd1, 6);
    issue("R4 R6 strobe-only fast", 2'b10, 16'h0000, 1'b1, 8'd0, 2);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk_on = 1'b0;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule